// File: doc/BRIEF.md
# Command-Block I/O Processor

This block lets a CPU hand off a whole device transfer with a single issue. The issue names a target device port and the memory address of a four-word command block. The engine reads that block from the shared memory port, decodes it, and then moves data on its own. It can move data from a device into memory or from memory out to a device. When the count runs out it raises an interrupt.

The engine shares one memory port with the CPU and always gives the CPU priority. In any cycle where the CPU asks for the port, the engine stays off it and tries again in the next cycle. Each of the four device ports is a plain FIFO port. Inbound ports offer a valid flag and data and take a pop strobe. Outbound ports offer a ready flag and take a push strobe.

The command block sits at four consecutive addresses starting at the block address:

| Offset | Contents |
|---|---|
| +0 | opcode |
| +1 | data address |
| +2 | word count |
| +3 | special-request flags |

Top module: `cbio_engine`

## Requirements
- R1: An issue (`issue_vld` high for one cycle) is accepted only while `busy_o` is low. `busy_o` is high in the cycle after acceptance. An issue that arrives while `busy_o` is high has no effect on the transfer in progress.
- R2: After acceptance the engine reads the command block at block address +0, +1, +2 and +3, in that order. These words are the opcode, the data address, the word count and the special-request flags.
- R3: The engine never drives `mem_req` in a cycle where `cpu_mem_req` is high. A stalled word is retried in a later cycle.
- R4: Opcode 0 moves data from device to memory. Whenever the selected device shows valid and the port is free, the engine pops one word and writes it to the data address. The data address then increments. This repeats for exactly `count` words.
- R5: Opcode 1 moves data from memory to device. Whenever the selected device shows ready and the port is free, the engine reads the word at the data address and pushes it to that device in the same cycle. The data address then increments. This repeats for exactly `count` words.
- R6: Any opcode value other than 0 or 1 ends the command right after the opcode word is read. No further memory access or device strobe occurs, `err_o` is set and the interrupt is raised.
- R7: A count of 0 ends the command after the fourth block word is read, with no data movement and `err_o` low.
- R8: On completion `busy_o` falls and `irq_o` rises on the same clock edge. `irq_o` then stays high until `irq_ack` is asserted.
- R9: If bit 0 of the special-request word is 1, a successful completion does not raise `irq_o`. `busy_o` still falls.
- R10: Only the device named in the accepted issue (`issue_dev`, 0 to 3) is ever popped or pushed. At most one device strobe is high in any cycle.
- R11: After reset `busy_o`, `irq_o`, `err_o`, `mem_req` and every device strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | CPU issues a command this cycle |
| issue_dev | input | 2 | Target device port of the issue |
| issue_addr | input | AW | Memory address of the command block |
| busy_o | output | 1 | A command is in progress |
| irq_o | output | 1 | Completion interrupt, held until acknowledged |
| irq_ack | input | 1 | CPU acknowledges the interrupt |
| err_o | output | 1 | The last command ended on a bad opcode |
| cpu_mem_req | input | 1 | CPU wants the memory port this cycle |
| mem_req | output | 1 | Engine uses the memory port this cycle |
| mem_we | output | 1 | Engine access is a write |
| mem_addr | output | AW | Engine access address |
| mem_wdata | output | DW | Engine write data |
| mem_rdata | input | DW | Read data, valid in the same cycle |
| dev_rd_valid | input | NDEV | Inbound device has a word |
| dev_rd_data | input | NDEV*DW | Inbound device words, device i in slice i |
| dev_rd_pop | output | NDEV | Pop strobe to inbound devices |
| dev_wr_ready | input | NDEV | Outbound device can take a word |
| dev_wr_push | output | NDEV | Push strobe to outbound devices |
| dev_wr_data | output | DW | Outbound word |

## Verification
The bench runs a direct transfer in each direction and then goes after the corner cases.

- **Port contention.** It raises `cpu_mem_req` in a fixed pattern while also pulling device ready low. An engine that ignored the CPU would collide on the port. An engine that advanced on a stalled cycle would skip or repeat words, and the scoreboard would see a wrong address or value.
- **Issue while busy.** A second issue arrives in the middle of a transfer. Latching it would redirect the block fetch or the device choice.
- **Bad opcode.** An engine that kept going after a bad opcode would read extra block words or move data.
- **Zero count.** A zero-count block with data waiting at the device would expose a count loop that underflows.
- **Quiet completion.** This case shows whether the special-request bit is honoured, and whether a device the engine did not select is ever touched.

// File: rtl/cbio_pkg.sv
package cbio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MOVE  = 2'd2
    } cbio_state_e;

    // Word offsets inside a command block; read in this order.
    localparam logic [1:0] FLD_OP   = 2'd0;
    localparam logic [1:0] FLD_ADDR = 2'd1;
    localparam logic [1:0] FLD_CNT  = 2'd2;
    localparam logic [1:0] FLD_SPEC = 2'd3;

    // Opcode values.
    localparam int unsigned OP_DEV2MEM = 0;
    localparam int unsigned OP_MEM2DEV = 1;

    // Bit of the special-request word that suppresses the interrupt.
    localparam int unsigned SPEC_QUIET_BIT = 0;

endpackage

// File: rtl/cbio_arb.sv
module cbio_arb #(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 16
) (
    input  logic          want,
    input  logic          want_we,
    input  logic [AW-1:0] want_addr,
    input  logic [DW-1:0] want_wdata,
    input  logic          cpu_req,
    output logic          grant,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    // CPU wins every cycle it asks; the engine only steals idle cycles.
    always_comb begin
        grant     = want & ~cpu_req;
        mem_req   = grant;
        mem_we    = grant & want_we;
        mem_addr  = grant ? want_addr : '0;
        mem_wdata = (grant && want_we) ? want_wdata : '0;
    end

endmodule

// File: rtl/cbio_devsel.sv
module cbio_devsel #(
    parameter int unsigned NDEV = 4,
    parameter int unsigned DW   = 16,
    parameter int unsigned DEVW = 2
) (
    input  logic [DEVW-1:0]    sel,
    input  logic [NDEV-1:0]    rd_valid,
    input  logic [NDEV*DW-1:0] rd_data,
    input  logic [NDEV-1:0]    wr_ready,
    input  logic               pop_en,
    input  logic               push_en,
    output logic               sel_valid,
    output logic               sel_ready,
    output logic [DW-1:0]      sel_data,
    output logic [NDEV-1:0]    rd_pop,
    output logic [NDEV-1:0]    wr_push
);

    logic [NDEV-1:0] hit;

    for (genvar g = 0; g < NDEV; g++) begin : g_port
        assign hit[g]     = (sel == DEVW'(g));
        assign rd_pop[g]  = pop_en & hit[g];
        assign wr_push[g] = push_en & hit[g];
    end

    always_comb begin
        sel_valid = 1'b0;
        sel_ready = 1'b0;
        sel_data  = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (hit[i]) begin
                sel_valid = sel_valid | rd_valid[i];
                sel_ready = sel_ready | wr_ready[i];
                sel_data  = sel_data | rd_data[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/cbio_seq.sv
module cbio_seq
    import cbio_pkg::*;
#(
    parameter int unsigned AW   = 12,
    parameter int unsigned DW   = 16,
    parameter int unsigned DEVW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_vld,
    input  logic [DEVW-1:0] issue_dev,
    input  logic [AW-1:0]   issue_addr,
    input  logic            irq_ack,
    input  logic            grant,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            sel_valid,
    input  logic            sel_ready,
    input  logic [DW-1:0]   sel_data,
    output logic            want,
    output logic            want_we,
    output logic [AW-1:0]   want_addr,
    output logic [DW-1:0]   want_wdata,
    output logic [DEVW-1:0] sel,
    output logic            pop_en,
    output logic            push_en,
    output logic            busy,
    output logic            irq,
    output logic            err
);

    typedef struct packed {
        cbio_state_e     st;
        logic [DEVW-1:0] dev;
        logic [AW-1:0]   base;
        logic [1:0]      idx;
        logic            dir_out;
        logic [AW-1:0]   dptr;
        logic [DW-1:0]   cnt;
        logic            quiet;
        logic            irq;
        logic            err;
    } seq_t;

    seq_t r_q, r_d;
    logic finish, fin_err, fin_quiet;

    always_comb begin
        r_d        = r_q;
        want       = 1'b0;
        want_we    = 1'b0;
        want_addr  = '0;
        want_wdata = '0;
        pop_en     = 1'b0;
        push_en    = 1'b0;
        finish     = 1'b0;
        fin_err    = 1'b0;
        fin_quiet  = r_q.quiet;

        if (irq_ack) begin
            r_d.irq = 1'b0;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (issue_vld) begin
                    r_d.st   = ST_FETCH;
                    r_d.dev  = issue_dev;
                    r_d.base = issue_addr;
                    r_d.idx  = FLD_OP;
                    r_d.err  = 1'b0;
                end
            end
            ST_FETCH: begin
                want      = 1'b1;
                want_addr = r_q.base + AW'(r_q.idx);
                if (grant) begin
                    r_d.idx = r_q.idx + 2'd1;
                    case (r_q.idx)
                        FLD_OP: begin
                            r_d.dir_out = mem_rdata[0];
                            if (mem_rdata > DW'(OP_MEM2DEV)) begin
                                finish  = 1'b1;
                                fin_err = 1'b1;
                            end
                        end
                        FLD_ADDR: r_d.dptr = mem_rdata[AW-1:0];
                        FLD_CNT:  r_d.cnt  = mem_rdata;
                        default: begin
                            r_d.quiet = mem_rdata[SPEC_QUIET_BIT];
                            fin_quiet = mem_rdata[SPEC_QUIET_BIT];
                            if (r_q.cnt == '0) begin
                                finish = 1'b1;
                            end else begin
                                r_d.st = ST_MOVE;
                            end
                        end
                    endcase
                end
            end
            ST_MOVE: begin
                want_addr = r_q.dptr;
                if (!r_q.dir_out) begin
                    want       = sel_valid;
                    want_we    = 1'b1;
                    want_wdata = sel_data;
                    pop_en     = grant;
                end else begin
                    want    = sel_ready;
                    push_en = grant;
                end
                if (grant) begin
                    r_d.dptr = r_q.dptr + AW'(1);
                    r_d.cnt  = r_q.cnt - DW'(1);
                    if (r_q.cnt == DW'(1)) begin
                        finish = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (finish) begin
            r_d.st  = ST_IDLE;
            r_d.err = fin_err;
            r_d.irq = r_d.irq | fin_err | ~fin_quiet;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel  = r_q.dev;
    assign busy = (r_q.st != ST_IDLE);
    assign irq  = r_q.irq;
    assign err  = r_q.err;

endmodule

// File: rtl/cbio_engine.sv
module cbio_engine #(
    parameter int unsigned AW   = 12,
    parameter int unsigned DW   = 16,
    parameter int unsigned NDEV = 4,
    localparam int unsigned DEVW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_vld,
    input  logic [DEVW-1:0]    issue_dev,
    input  logic [AW-1:0]      issue_addr,
    output logic               busy_o,
    output logic               irq_o,
    input  logic               irq_ack,
    output logic               err_o,
    input  logic               cpu_mem_req,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic [NDEV-1:0]    dev_rd_valid,
    input  logic [NDEV*DW-1:0] dev_rd_data,
    output logic [NDEV-1:0]    dev_rd_pop,
    input  logic [NDEV-1:0]    dev_wr_ready,
    output logic [NDEV-1:0]    dev_wr_push,
    output logic [DW-1:0]      dev_wr_data
);

    logic            want, want_we, grant;
    logic [AW-1:0]   want_addr;
    logic [DW-1:0]   want_wdata;
    logic [DEVW-1:0] sel;
    logic            pop_en, push_en;
    logic            sel_valid, sel_ready;
    logic [DW-1:0]   sel_data;

    cbio_seq #(.AW(AW), .DW(DW), .DEVW(DEVW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_vld  (issue_vld),
        .issue_dev  (issue_dev),
        .issue_addr (issue_addr),
        .irq_ack    (irq_ack),
        .grant      (grant),
        .mem_rdata  (mem_rdata),
        .sel_valid  (sel_valid),
        .sel_ready  (sel_ready),
        .sel_data   (sel_data),
        .want       (want),
        .want_we    (want_we),
        .want_addr  (want_addr),
        .want_wdata (want_wdata),
        .sel        (sel),
        .pop_en     (pop_en),
        .push_en    (push_en),
        .busy       (busy_o),
        .irq        (irq_o),
        .err        (err_o)
    );

    cbio_arb #(.AW(AW), .DW(DW)) u_arb (
        .want       (want),
        .want_we    (want_we),
        .want_addr  (want_addr),
        .want_wdata (want_wdata),
        .cpu_req    (cpu_mem_req),
        .grant      (grant),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    cbio_devsel #(.NDEV(NDEV), .DW(DW), .DEVW(DEVW)) u_devsel (
        .sel       (sel),
        .rd_valid  (dev_rd_valid),
        .rd_data   (dev_rd_data),
        .wr_ready  (dev_wr_ready),
        .pop_en    (pop_en),
        .push_en   (push_en),
        .sel_valid (sel_valid),
        .sel_ready (sel_ready),
        .sel_data  (sel_data),
        .rd_pop    (dev_rd_pop),
        .wr_push   (dev_wr_push)
    );

    // Outbound word comes straight from the memory read of the same cycle.
    assign dev_wr_data = mem_rdata;

endmodule

// File: rtl/cbio_engine_chk.sv
module cbio_engine_chk #(
    parameter int unsigned NDEV = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_o,
    input logic            irq_o,
    input logic            irq_ack,
    input logic            err_o,
    input logic            cpu_mem_req,
    input logic            mem_req,
    input logic            mem_we,
    input logic [NDEV-1:0] dev_rd_valid,
    input logic [NDEV-1:0] dev_rd_pop,
    input logic [NDEV-1:0] dev_wr_ready,
    input logic [NDEV-1:0] dev_wr_push
);

    AST_CPU_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_mem_req |-> !mem_req); // R3

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req && dev_rd_pop == '0 && dev_wr_push == '0)); // R1

    AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_rd_pop | dev_wr_push)); // R10

    AST_POP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_rd_pop) |-> (mem_req && mem_we)); // R4

    AST_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd_pop & ~dev_rd_valid) == '0); // R4

    AST_PUSH_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_wr_push) |-> (mem_req && !mem_we)); // R5

    AST_PUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr_push & ~dev_wr_ready) == '0); // R5

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_ack) |=> irq_o); // R8

    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $fell(busy_o)); // R8

    AST_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> irq_o); // R6

endmodule

bind cbio_engine cbio_engine_chk #(.NDEV(NDEV)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .irq_o        (irq_o),
    .irq_ack      (irq_ack),
    .err_o        (err_o),
    .cpu_mem_req  (cpu_mem_req),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .dev_rd_valid (dev_rd_valid),
    .dev_rd_pop   (dev_rd_pop),
    .dev_wr_ready (dev_wr_ready),
    .dev_wr_push  (dev_wr_push)
);

// File: tb/sim_cbio_engine.sv
module sim_cbio_engine;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int ND = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             issue_vld = 1'b0;
    logic [1:0]       issue_dev = '0;
    logic [AW-1:0]    issue_addr = '0;
    logic             busy_o, irq_o, err_o;
    logic             irq_ack = 1'b0;
    logic             cpu_mem_req = 1'b0;
    logic             mem_req, mem_we;
    logic [AW-1:0]    mem_addr;
    logic [DW-1:0]    mem_wdata, mem_rdata;
    logic [ND-1:0]    dev_rd_valid, dev_rd_pop, dev_wr_push;
    logic [ND*DW-1:0] dev_rd_data;
    logic [ND-1:0]    dev_wr_ready = '1;
    logic [DW-1:0]    dev_wr_data;

    cbio_engine #(.AW(AW), .DW(DW), .NDEV(ND)) u0 (.*);

    // ---------------- memory and device models ----------------
    logic [DW-1:0] ram [256];
    logic [DW-1:0] src_data [ND][16];
    logic [3:0]    src_wp [ND];
    logic [3:0]    src_rp [ND];
    logic          ld_ram = 1'b0, ld_src = 1'b0;
    logic [1:0]    ld_dev = '0;
    logic [7:0]    ld_addr = '0;
    logic [DW-1:0] ld_data = '0;

    initial begin
        for (int d = 0; d < ND; d++) begin
            src_wp[d] = '0;
            src_rp[d] = '0;
        end
    end

    assign mem_rdata = ram[mem_addr[7:0]];

    always_comb begin
        for (int d = 0; d < ND; d++) begin
            dev_rd_valid[d]          = (src_rp[d] != src_wp[d]);
            dev_rd_data[d*DW +: DW]  = src_data[d][src_rp[d]];
        end
    end

    always @(posedge clk) begin
        if (ld_ram) ram[ld_addr] <= ld_data;
        if (mem_req && mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        if (ld_src) begin
            src_data[ld_dev][src_wp[ld_dev]] <= ld_data;
            src_wp[ld_dev] <= src_wp[ld_dev] + 4'd1;
        end
        for (int d = 0; d < ND; d++) begin
            if (dev_rd_pop[d]) src_rp[d] <= src_rp[d] + 4'd1;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
    typedef struct { logic [1:0] dev; logic [DW-1:0] d; } push_t;
    wr_t           exp_wr[$];
    push_t         exp_push[$];
    logic [AW-1:0] rd_log[$];

    // Monitor: samples one time unit after each falling edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (cpu_mem_req && mem_req) chk("R3 port collision", 1, 0);
            if (mem_req && !mem_we) rd_log.push_back(mem_addr);
            if (mem_req && mem_we) begin
                if (exp_wr.size() == 0) begin
                    chk("R4 unexpected write addr", 32'(mem_addr), 32'hFFFF_FFFF);
                end else begin
                    wr_t e;
                    e = exp_wr.pop_front();
                    chk("R4 write addr", 32'(mem_addr), 32'(e.a));
                    chk("R4 write data", 32'(mem_wdata), 32'(e.d));
                end
            end
            for (int d = 0; d < ND; d++) begin
                if (dev_wr_push[d]) begin
                    if (exp_push.size() == 0) begin
                        chk("R5 unexpected push dev", d, 32'hFFFF_FFFF);
                    end else begin
                        push_t p;
                        p = exp_push.pop_front();
                        chk("R10 push device", d, 32'(p.dev));
                        chk("R5 push data", 32'(dev_wr_data), 32'(p.d));
                    end
                end
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic load_ram(input logic [7:0] a, input logic [DW-1:0] d);
        @(negedge clk); ld_ram = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk); ld_ram = 1'b0;
    endtask

    task automatic load_src(input logic [1:0] dev, input logic [DW-1:0] d);
        @(negedge clk); ld_src = 1'b1; ld_dev = dev; ld_data = d;
        @(negedge clk); ld_src = 1'b0;
    endtask

    task automatic put_block(input logic [7:0] b, input logic [DW-1:0] op, adr, cnt, spec);
        load_ram(b, op);
        load_ram(b + 8'd1, adr);
        load_ram(b + 8'd2, cnt);
        load_ram(b + 8'd3, spec);
    endtask

    task automatic issue(input logic [1:0] dev, input logic [AW-1:0] b, input string tag);
        @(negedge clk); issue_vld = 1'b1; issue_dev = dev; issue_addr = b;
        @(negedge clk); issue_vld = 1'b0;
        #1 chk({tag, " busy after issue"}, 32'(busy_o), 1);
    endtask

    task automatic wait_idle(input string tag);
        int k;
        k = 0;
        while (busy_o && k < 500) begin
            @(negedge clk); #1;
            k++;
        end
        if (k >= 500) chk({tag, " timeout"}, 1, 0);
    endtask

    task automatic ack_irq(input string tag);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1 chk({tag, " irq cleared by ack"}, 32'(irq_o), 0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 busy", 32'(busy_o), 0);
        chk("R11 irq", 32'(irq_o), 0);
        chk("R11 err", 32'(err_o), 0);
        chk("R11 mem_req", 32'(mem_req), 0);
        chk("R11 strobes", 32'({dev_rd_pop, dev_wr_push}), 0);

        // Device to memory from device 2; device 0 holds a word that must stay put.
        load_src(2'd2, 16'hA001);
        load_src(2'd2, 16'hA002);
        load_src(2'd2, 16'hA003);
        load_src(2'd0, 16'h5555);
        put_block(8'h20, 16'd0, 16'h0100, 16'd3, 16'd0);
        exp_wr.push_back('{12'h100, 16'hA001});
        exp_wr.push_back('{12'h101, 16'hA002});
        exp_wr.push_back('{12'h102, 16'hA003});
        r0 = rd_log.size();
        issue(2'd2, 12'h020, "R1");
        wait_idle("R4");
        chk("R8 irq at completion", 32'(irq_o), 1);
        chk("R4 err clear", 32'(err_o), 0);
        chk("R4 all writes seen", exp_wr.size(), 0);
        chk("R2 fetch read count", rd_log.size() - r0, 4);
        for (int i = 0; i < 4; i++)
            chk("R2 fetch order", 32'(rd_log[r0+i]), 32'h20 + i);
        chk("R10 device 0 untouched", 32'(src_rp[0]), 0);
        chk("R4 device 2 drained", 32'(src_rp[2]), 3);
        repeat (3) @(negedge clk);
        #1 chk("R8 irq held", 32'(irq_o), 1);
        ack_irq("R8");

        // Memory to device 1 under CPU contention and device back-pressure.
        for (int i = 0; i < 4; i++) load_ram(8'h40 + 8'(i), 16'hB000 + 16'(i));
        put_block(8'h30, 16'd1, 16'h0040, 16'd4, 16'd0);
        put_block(8'h50, 16'd1, 16'h0060, 16'd2, 16'd0);
        for (int i = 0; i < 4; i++) exp_push.push_back('{2'd1, 16'hB000 + 16'(i)});
        r0 = rd_log.size();
        issue(2'd1, 12'h030, "R5");
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            cpu_mem_req  = (k % 3 == 0);
            dev_wr_ready = (k % 4 == 1) ? 4'h0 : 4'hF;
            issue_vld    = (k == 3);
            issue_dev    = 2'd3;
            issue_addr   = 12'h050;
        end
        @(negedge clk);
        cpu_mem_req  = 1'b0;
        dev_wr_ready = 4'hF;
        issue_vld    = 1'b0;
        #1;
        wait_idle("R5");
        chk("R5 all pushes seen", exp_push.size(), 0);
        chk("R1 busy issue ignored, reads", rd_log.size() - r0, 8);
        chk("R8 irq after out transfer", 32'(irq_o), 1);
        ack_irq("R5");

        // Bad opcode.
        put_block(8'h70, 16'd7, 16'h0010, 16'd2, 16'd1);
        r0 = rd_log.size();
        issue(2'd0, 12'h070, "R6");
        wait_idle("R6");
        chk("R6 err set", 32'(err_o), 1);
        chk("R6 irq despite quiet bit", 32'(irq_o), 1);
        chk("R6 only opcode read", rd_log.size() - r0, 1);
        chk("R6 device 0 untouched", 32'(src_rp[0]), 0);
        ack_irq("R6");

        // Zero count with data waiting at the device.
        put_block(8'h78, 16'd0, 16'h0010, 16'd0, 16'd0);
        r0 = rd_log.size();
        issue(2'd0, 12'h078, "R7");
        wait_idle("R7");
        chk("R7 irq", 32'(irq_o), 1);
        chk("R7 err clear", 32'(err_o), 0);
        chk("R7 block reads only", rd_log.size() - r0, 4);
        chk("R7 no pop", 32'(src_rp[0]), 0);
        ack_irq("R7");

        // Quiet completion: one word from device 0.
        put_block(8'h7C, 16'd0, 16'h0090, 16'd1, 16'd1);
        exp_wr.push_back('{12'h090, 16'h5555});
        issue(2'd0, 12'h07C, "R9");
        wait_idle("R9");
        repeat (2) @(negedge clk);
        #1;
        chk("R9 no irq", 32'(irq_o), 0);
        chk("R9 write done", exp_wr.size(), 0);
        chk("R9 device 0 popped", 32'(src_rp[0]), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule